// File: doc/BRIEF.md
# Stop-Mode Wake-Up Stabilization Controller

This block sequences a processor core through its power-down states and back. While running, the core may ask to idle or to stop. Either request removes the core clock enable. Idle ends as soon as an enabled interrupt is pending. Stop is a data-retention state. It can be left in only two ways, and each way uses its own stabilization delay with its own timebase.

An interrupt wake-up moves the block into a stabilizing wait. That wait lasts a fixed number of basic-timer ticks, and during it the clock enable stays low while core reset is not asserted. A reset, whether it arrives at power-up, during stop or during any wait, starts a much longer wait. That wait is counted in raw oscillator cycles, and core reset stays held for the whole of it. In both cases the counter restarts from zero when the wait begins. Further interrupts during a wait do not shorten it.

The current mode is reported on a two-bit output. The encoding is 0 normal, 1 idle, 2 stop and 3 stabilizing.

Top module: `pwr_stop_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `mode_o` is 3, `core_rst_o` is 1 and `core_clk_en_o` is 0.
- R2: After the last clock edge with `rst` high, the block stays in mode 3 with core reset held for `RST_WAIT - 1` further edges. At the edge after that (edge `RST_WAIT` with `rst` low) it enters mode 0, with `core_rst_o` 0 and `core_clk_en_o` 1.
- R3: In mode 0, a sampled `stop_req_i` moves the block to mode 2 at the next edge, with `core_clk_en_o` 0 and `core_rst_o` 0.
- R4: When `stop_req_i` and `idle_req_i` are both high in mode 0, stop wins and the next mode is 2.
- R5: In mode 0, `idle_req_i` alone moves the block to mode 1 with the clock enable low. In mode 1, a sampled `irq_i` returns it to mode 0 at the next edge.
- R6: In mode 2, a sampled `irq_i` moves the block to mode 3 with core reset low. It returns to mode 0 at the edge of the `IRQ_TICKS`-th `bt_tick_i` pulse sampled after that edge. A tick sampled in the same cycle as the waking interrupt is not counted.
- R7: `irq_i` has no effect on the length of either stabilizing wait.
- R8: A reset during stop or during an interrupt-initiated wait restarts the long wait from zero, as R2 describes.
- R9: In mode 2, `stop_req_i`, `idle_req_i` and `bt_tick_i` have no effect. The block stays in mode 2 until an interrupt arrives. In mode 0, `irq_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock; also the timebase of the reset wait |
| rst | input | 1 | Synchronous active-high reset; starts the long stabilization wait |
| stop_req_i | input | 1 | Request to enter data-retention stop |
| idle_req_i | input | 1 | Request to enter idle |
| irq_i | input | 1 | An enabled interrupt is pending |
| bt_tick_i | input | 1 | One-cycle basic-timer tick pulse |
| core_clk_en_o | output | 1 | Core clock enable, high only in normal mode |
| core_rst_o | output | 1 | Core reset hold, high during the reset-initiated wait |
| mode_o | output | 2 | 0 normal, 1 idle, 2 stop, 3 stabilizing |

## Verification
Two functions can fall in the same cycle, and the bench provokes both. The first is a stop request and an idle request together: both are driven high for one cycle in normal mode, and the bench judges that the block lands in stop rather than idle. The second is a waking interrupt and a basic-timer tick together: both are driven in the same cycle while in stop. The bench then judges that fifteen further ticks still leave the block stabilizing and that the sixteenth releases it, which shows the coincident tick was not counted. Interrupts are also held high during both waits, to show that neither wait is shortened.

// File: rtl/pwr_stop_pkg.sv
package pwr_stop_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_IDLE   = 2'd1,
        MODE_STOP   = 2'd2,
        MODE_STAB   = 2'd3
    } pwr_mode_e;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_IDLE     = 3'd1,
        ST_STOP     = 3'd2,
        ST_WAIT_IRQ = 3'd3,
        ST_WAIT_RST = 3'd4
    } pwr_state_e;

    function automatic pwr_mode_e state_to_mode(pwr_state_e s);
        case (s)
            ST_RUN:  return MODE_NORMAL;
            ST_IDLE: return MODE_IDLE;
            ST_STOP: return MODE_STOP;
            default: return MODE_STAB;
        endcase
    endfunction

endpackage

// File: rtl/pwr_stab_counter.sv
module pwr_stab_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         step_i,
    input  logic [W-1:0] last_i,
    output logic         done_o
);
    logic [W-1:0] count_q;

    assign done_o = step_i && (count_q == last_i);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            count_q <= '0;
        end else if (step_i) begin
            if (done_o) count_q <= '0;
            else        count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_stop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req_i,
    input  logic       idle_req_i,
    input  logic       irq_i,
    input  logic       bt_tick_i,
    input  logic       cnt_done_i,
    output logic       cnt_clear_o,
    output logic       cnt_step_o,
    output logic       long_wait_o,
    output pwr_state_e state_o
);
    pwr_state_e state_q, state_d;

    always_comb begin
        state_d     = state_q;
        cnt_clear_o = 1'b0;
        cnt_step_o  = 1'b0;
        long_wait_o = 1'b0;
        case (state_q)
            ST_RUN: begin
                if (stop_req_i)      state_d = ST_STOP;
                else if (idle_req_i) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (irq_i) state_d = ST_RUN;
            end
            ST_STOP: begin
                if (irq_i) begin
                    state_d     = ST_WAIT_IRQ;
                    cnt_clear_o = 1'b1;
                end
            end
            ST_WAIT_IRQ: begin
                cnt_step_o = bt_tick_i;
                if (cnt_done_i) state_d = ST_RUN;
            end
            ST_WAIT_RST: begin
                cnt_step_o  = 1'b1;
                long_wait_o = 1'b1;
                if (cnt_done_i) state_d = ST_RUN;
            end
            default: state_d = ST_WAIT_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT_RST;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/pwr_stop_ctrl.sv
module pwr_stop_ctrl
    import pwr_stop_pkg::*;
#(
    parameter int RST_WAIT  = 65536,
    parameter int IRQ_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req_i,
    input  logic       idle_req_i,
    input  logic       irq_i,
    input  logic       bt_tick_i,
    output logic       core_clk_en_o,
    output logic       core_rst_o,
    output logic [1:0] mode_o
);
    localparam int MAX_WAIT = (RST_WAIT > IRQ_TICKS) ? RST_WAIT : IRQ_TICKS;
    localparam int CNT_W    = (MAX_WAIT > 2) ? $clog2(MAX_WAIT) : 1;
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(RST_WAIT - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(IRQ_TICKS - 1);

    pwr_state_e       state;
    logic             cnt_clear, cnt_step, cnt_done, long_wait;
    logic [CNT_W-1:0] cnt_last;

    assign cnt_last = long_wait ? LONG_LAST : SHORT_LAST;

    pwr_mode_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .stop_req_i  (stop_req_i),
        .idle_req_i  (idle_req_i),
        .irq_i       (irq_i),
        .bt_tick_i   (bt_tick_i),
        .cnt_done_i  (cnt_done),
        .cnt_clear_o (cnt_clear),
        .cnt_step_o  (cnt_step),
        .long_wait_o (long_wait),
        .state_o     (state)
    );

    pwr_stab_counter #(.W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .clear_i (cnt_clear),
        .step_i  (cnt_step),
        .last_i  (cnt_last),
        .done_o  (cnt_done)
    );

    assign core_clk_en_o = (state == ST_RUN);
    assign core_rst_o    = (state == ST_WAIT_RST);
    assign mode_o        = state_to_mode(state);
endmodule

// File: rtl/pwr_stop_ctrl_chk.sv
module pwr_stop_ctrl_chk
    import pwr_stop_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       stop_req_i,
    input logic       idle_req_i,
    input logic       irq_i,
    input logic       bt_tick_i,
    input logic       core_clk_en_o,
    input logic       core_rst_o,
    input logic [1:0] mode_o
);
    // R1
    reset_wait_chk: assert property (@(posedge clk)
        rst |=> (core_rst_o && !core_clk_en_o && mode_o == MODE_STAB));

    // R2
    rst_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        core_rst_o |-> (!core_clk_en_o && mode_o == MODE_STAB));

    // R2
    release_to_normal_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst_o) |-> (mode_o == MODE_NORMAL && core_clk_en_o));

    // R3
    stop_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_NORMAL && stop_req_i) |=> (mode_o == MODE_STOP && !core_clk_en_o));

    // R4
    stop_over_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_NORMAL && stop_req_i && idle_req_i) |=> (mode_o == MODE_STOP));

    // R5
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_IDLE && irq_i) |=> (mode_o == MODE_NORMAL));

    // R6
    irq_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_STOP && irq_i) |=> (mode_o == MODE_STAB && !core_rst_o));

    // R7
    no_tick_no_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_STAB && !core_rst_o && !bt_tick_i) |=> (mode_o == MODE_STAB));

    // R9
    stop_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_STOP && !irq_i) |=> (mode_o == MODE_STOP));
endmodule

bind pwr_stop_ctrl pwr_stop_ctrl_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .stop_req_i    (stop_req_i),
    .idle_req_i    (idle_req_i),
    .irq_i         (irq_i),
    .bt_tick_i     (bt_tick_i),
    .core_clk_en_o (core_clk_en_o),
    .core_rst_o    (core_rst_o),
    .mode_o        (mode_o)
);

// File: tb/pwr_stop_ctrl_tb_top.sv
module pwr_stop_ctrl_tb_top;
    localparam int RW = 64;
    localparam int IT = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stop_req = 1'b0, idle_req = 1'b0, irq = 1'b0, tick = 1'b0;
    logic       clk_en, core_rst;
    logic [1:0] mode;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pwr_stop_ctrl #(.RST_WAIT(RW), .IRQ_TICKS(IT)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .stop_req_i    (stop_req),
        .idle_req_i    (idle_req),
        .irq_i         (irq),
        .bt_tick_i     (tick),
        .core_clk_en_o (clk_en),
        .core_rst_o    (core_rst),
        .mode_o        (mode)
    );

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_state(string req, int m, int en, int rs);
        chk(req, "mode", int'(mode), m);
        chk(req, "clk_en", int'(clk_en), en);
        chk(req, "core_rst", int'(core_rst), rs);
    endtask

    task automatic pulse_ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; cyc(1);
            tick = 1'b0; irq = 1'b1; cyc(1);  // R7: interrupt during wait
            irq = 1'b0;
        end
    endtask

    // R1, R2, R7: power-up wait with interrupt held high
    task automatic t_reset_wait();
        rst = 1'b1; cyc(3);
        chk_state("R1", 3, 0, 1);
        rst = 1'b0; irq = 1'b1;
        cyc(RW - 1);
        chk_state("R2", 3, 0, 1);
        irq = 1'b0;
        cyc(1);
        chk_state("R2", 0, 1, 0);
    endtask

    // R3, R4, R9: simultaneous stop and idle, then ignored inputs in stop
    task automatic t_stop_entry();
        stop_req = 1'b1; idle_req = 1'b1; cyc(1);
        stop_req = 1'b0; idle_req = 1'b0;
        chk_state("R4", 2, 0, 0);
        idle_req = 1'b1; stop_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick = 1'b1; cyc(1); tick = 1'b0; cyc(1);
        end
        idle_req = 1'b0; stop_req = 1'b0;
        chk_state("R9", 2, 0, 0);
    endtask

    // R6, R7: wake with coincident tick, count the short wait
    task automatic t_irq_wake();
        irq = 1'b1; tick = 1'b1; cyc(1);
        irq = 1'b0; tick = 1'b0;
        chk_state("R6", 3, 0, 0);
        pulse_ticks(IT - 1);
        chk_state("R7", 3, 0, 0);
        tick = 1'b1; cyc(1); tick = 1'b0;
        chk_state("R6", 0, 1, 0);
    endtask

    // R5, R9: idle and release, interrupt ignored in normal
    task automatic t_idle();
        idle_req = 1'b1; cyc(1); idle_req = 1'b0;
        chk_state("R5", 1, 0, 0);
        cyc(3);
        chk_state("R5", 1, 0, 0);
        irq = 1'b1; cyc(1); irq = 1'b0;
        chk_state("R5", 0, 1, 0);
        irq = 1'b1; cyc(2); irq = 1'b0;
        chk_state("R9", 0, 1, 0);
    endtask

    // R3, R8: reset in the middle of a short wait restarts the long wait
    task automatic t_rst_restart();
        stop_req = 1'b1; cyc(1); stop_req = 1'b0;
        chk_state("R3", 2, 0, 0);
        irq = 1'b1; cyc(1); irq = 1'b0;
        pulse_ticks(5);
        rst = 1'b1; cyc(1); rst = 1'b0;
        chk_state("R8", 3, 0, 1);
        cyc(RW - 1);
        chk_state("R8", 3, 0, 1);
        cyc(1);
        chk_state("R8", 0, 1, 0);
    endtask

    initial begin
        t_reset_wait();
        t_stop_entry();
        t_irq_wake();
        t_idle();
        t_rst_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule